// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers the event signals of a multi-channel DMA engine into one place that software can read and clear. Each channel reports four kinds of event as one-cycle pulses: transfer complete, source-side fault, destination-side fault and descriptor-setup fault. Each event kind has its own sticky pending register. Every pending register has a filtered view, in which a pending bit counts only when that channel's interrupt enable is set. A single active-high level interrupt is raised while any filtered bit of any kind is set.

Software clears pending events one bit at a time by writing ones to the pending register. A live register shows which channels are running. Two plain read/write words carry a channel-group priority and an arbitration setting, which the block passes out to the channel scheduler. Both words reset to zero, which means equal priority for every channel. Register access uses a simple port: a write strobe with address and data, and read data that follows the address combinationally.

Top module: `dma_irq_agg`

## Requirements
- R1: An event pulse on channel i of any kind sets bit i of that kind's pending register at the next clock edge. The bit stays set until it is cleared.
- R2: Writing to a pending register clears, at the next edge, every bit written as 1. Bits written as 0 keep their value. The pending registers are at offset 0x810 (complete), 0x814 (source fault), 0x818 (destination fault) and 0x81C (setup fault).
- R3: When an event pulse and a clearing write hit the same bit in the same cycle, the event wins and the bit stays set.
- R4: The filtered views read at 0x800, 0x804, 0x808 and 0x80C, with the same kind order as R2. Each view equals its pending register ANDed with the per-channel interrupt-enable input.
- R5: The interrupt output is high exactly when any bit of any of the four filtered views is set.
- R6: Offset 0x820 reads the busy input of each channel live, with bit i belonging to channel i.
- R7: Offset 0x824 (group priority) and offset 0x828 (arbitration) are 32-bit read/write words. Each drives its own output port. Writing 0 to 0x828 selects equal priority for all channels.
- R8: With N channels, register bits N and above read as zero, and event or enable activity on them cannot be seen.
- R9: After reset, every pending bit, both read/write words and the interrupt output are zero.
- R10: Writes to the filtered views, to the busy offset or to unmapped offsets change no state. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_done | input | N | Transfer-complete pulse per channel |
| evt_src_err | input | N | Source-fault pulse per channel |
| evt_dst_err | input | N | Destination-fault pulse per channel |
| evt_cfg_err | input | N | Setup-fault pulse per channel |
| ch_irq_en | input | N | Per-channel interrupt enable level |
| ch_busy | input | N | Per-channel running level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| grp_prio | output | 32 | Group priority word |
| arb_cfg | output | 32 | Arbitration word |
| irq | output | 1 | Shared level interrupt |

## Verification
The bench builds the block with N = 24. With that value, bits 24 to 31 of every register are above the channel range, so writing all ones and driving all-ones events checks that those bits stay at zero. Random traffic drives all four event kinds, the enables, the busy levels and writes to every offset, including the read-only and unmapped ones. A bench model tracks pending, filtered and word state on every cycle. Directed cases cover the event-versus-clear collision, writes of zero, and the initial clear-all write.

// File: rtl/dma_irq_pkg.sv
// Package: shared offsets and sizes for the DMA interrupt aggregator.
// Assumes byte offsets are compared on the full address port width.
package dma_irq_pkg;
    localparam int unsigned NUM_KINDS  = 4;   // complete, src fault, dst fault, setup fault
    localparam int unsigned WORD_W     = 32;
    localparam logic [11:0] OFS_VIEW0  = 12'h800;
    localparam logic [11:0] OFS_PEND0  = 12'h810;
    localparam logic [11:0] OFS_BUSY   = 12'h820;
    localparam logic [11:0] OFS_GRP    = 12'h824;
    localparam logic [11:0] OFS_ARB    = 12'h828;
    localparam logic [11:0] OFS_STRIDE = 12'h004;
endpackage

// File: rtl/dma_evt_latch.sv
// Module: sticky pending bits for one event kind.
// Each bit is set by an event pulse and cleared by a write-one mask.
// An event wins over a clear that arrives in the same cycle.
// Assumes clr_mask is already qualified by the write strobe.
module dma_evt_latch #(
    parameter int unsigned N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend
);
    // Update pending bits: clear first, then merge new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | evt;
    end

    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~evt) != '0) |=> ((pend & $past(clr_mask & ~evt)) == '0));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt == '0) && (clr_mask == '0)) |=> $stable(pend));
    assert_collide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & clr_mask) != '0) |=> ((pend & $past(evt & clr_mask)) == $past(evt & clr_mask)));
endmodule

// File: rtl/dma_irq_rdmux.sv
// Module: read-data selection for the aggregator register window.
// Purely combinational. Channel vectors are zero-extended to the word width.
// Unmapped offsets return zero.
module dma_irq_rdmux
    import dma_irq_pkg::*;
#(
    parameter int unsigned N      = 24,
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_KINDS-1:0][N-1:0] pend,
    input  logic [NUM_KINDS-1:0][N-1:0] view,
    input  logic [N-1:0]                busy,
    input  logic [WORD_W-1:0]           grp,
    input  logic [WORD_W-1:0]           arb,
    output logic [WORD_W-1:0]           rdata
);
    // Compare the offset against each mapped register and pick its contents.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (addr == ADDR_W'(OFS_VIEW0 + OFS_STRIDE * 12'(k))) rdata = WORD_W'(view[k]);
            if (addr == ADDR_W'(OFS_PEND0 + OFS_STRIDE * 12'(k))) rdata = WORD_W'(pend[k]);
        end
        if (addr == ADDR_W'(OFS_BUSY)) rdata = WORD_W'(busy);
        if (addr == ADDR_W'(OFS_GRP))  rdata = grp;
        if (addr == ADDR_W'(OFS_ARB))  rdata = arb;
    end
endmodule

// File: rtl/dma_irq_agg.sv
// Module: top of the DMA interrupt aggregator.
// It latches four event kinds per channel, forms enable-filtered views,
// raises one level interrupt, shows busy levels live, and holds the
// group-priority and arbitration words.
// Assumes N <= 32 and reg_addr carries a byte offset.
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int unsigned N      = 24,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_done,
    input  logic [N-1:0]      evt_src_err,
    input  logic [N-1:0]      evt_dst_err,
    input  logic [N-1:0]      evt_cfg_err,
    input  logic [N-1:0]      ch_irq_en,
    input  logic [N-1:0]      ch_busy,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [31:0]       grp_prio,
    output logic [31:0]       arb_cfg,
    output logic              irq
);
    localparam logic [WORD_W-1:0] CH_MASK = WORD_W'({N{1'b1}});

    logic [NUM_KINDS-1:0][N-1:0] evt_all;
    logic [NUM_KINDS-1:0][N-1:0] clr_all;
    logic [NUM_KINDS-1:0][N-1:0] pend_all;
    logic [NUM_KINDS-1:0][N-1:0] view_all;
    logic [NUM_KINDS-1:0]        kind_hit;

    // Gather the event inputs in offset order.
    always_comb begin
        evt_all[0] = evt_done;
        evt_all[1] = evt_src_err;
        evt_all[2] = evt_dst_err;
        evt_all[3] = evt_cfg_err;
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        // Turn a write to this kind's pending offset into a clear mask.
        always_comb begin
            clr_all[k] = '0;
            if (reg_we && reg_addr == ADDR_W'(OFS_PEND0 + OFS_STRIDE * 12'(k)))
                clr_all[k] = reg_wdata[N-1:0];
        end

        dma_evt_latch #(.N(N)) u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_all[k]),
            .clr_mask (clr_all[k]),
            .pend     (pend_all[k])
        );

        // Filter the pending bits with the channel enables.
        always_comb begin
            view_all[k] = pend_all[k] & ch_irq_en;
            kind_hit[k] = |view_all[k];
        end
    end

    // The interrupt is the OR of all four filtered views.
    always_comb irq = |kind_hit;

    // Hold the group-priority and arbitration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_prio <= '0;
            arb_cfg  <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(OFS_GRP)) grp_prio <= reg_wdata;
            if (reg_addr == ADDR_W'(OFS_ARB)) arb_cfg  <= reg_wdata;
        end
    end

    dma_irq_rdmux #(.N(N), .ADDR_W(ADDR_W)) u_rdmux (
        .addr  (reg_addr),
        .pend  (pend_all),
        .view  (view_all),
        .busy  (ch_busy),
        .grp   (grp_prio),
        .arb   (arb_cfg),
        .rdata (reg_rdata)
    );

    assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend_all[0] | pend_all[1] | pend_all[2] | pend_all[3]) != '0));
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~CH_MASK) == '0 || reg_addr == ADDR_W'(OFS_GRP) || reg_addr == ADDR_W'(OFS_ARB));
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!irq && grp_prio == '0 && arb_cfg == '0));
    assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(grp_prio) && $stable(arb_cfg)));
endmodule

// File: tb/dma_irq_agg_tb.sv
// Bench: random traffic plus directed corners, checked against a bench model.
module dma_irq_agg_tb_top;
    localparam int unsigned N       = 24;
    localparam int unsigned ADDR_W  = 12;
    localparam time         CLK_PER = 10ns;
    localparam logic [31:0] CMASK   = 32'h00FF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      evt_done, evt_src_err, evt_dst_err, evt_cfg_err;
    logic [N-1:0]      ch_irq_en, ch_busy;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [31:0]       reg_wdata, reg_rdata, grp_prio, arb_cfg;
    logic              irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_pend [4];
    logic [31:0] m_grp, m_arb;

    dma_irq_agg #(.N(N), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .evt_done(evt_done), .evt_src_err(evt_src_err),
        .evt_dst_err(evt_dst_err), .evt_cfg_err(evt_cfg_err),
        .ch_irq_en(ch_irq_en), .ch_busy(ch_busy),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .grp_prio(grp_prio), .arb_cfg(arb_cfg), .irq(irq)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        logic [31:0] en = 32'(ch_irq_en);
        case (a)
            12'h800: return m_pend[0] & en;
            12'h804: return m_pend[1] & en;
            12'h808: return m_pend[2] & en;
            12'h80C: return m_pend[3] & en;
            12'h810: return m_pend[0];
            12'h814: return m_pend[1];
            12'h818: return m_pend[2];
            12'h81C: return m_pend[3];
            12'h820: return 32'(ch_busy);
            12'h824: return m_grp;
            12'h828: return m_arb;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [11:0] a);
        if (a < 12'h810) return "R4";
        if (a < 12'h820) return "R1";
        if (a == 12'h820) return "R6";
        if (a == 12'h824 || a == 12'h828) return "R7";
        return "R10";
    endfunction

    function automatic logic exp_irq();
        logic [31:0] en = 32'(ch_irq_en);
        return |((m_pend[0] | m_pend[1] | m_pend[2] | m_pend[3]) & en);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one cycle with the inputs currently driven, update the model, then check.
    task automatic tick();
        logic [31:0] nxt [4];
        logic [31:0] ev [4];
        ev[0] = 32'(evt_done); ev[1] = 32'(evt_src_err);
        ev[2] = 32'(evt_dst_err); ev[3] = 32'(evt_cfg_err);
        for (int k = 0; k < 4; k++) begin
            nxt[k] = m_pend[k];
            if (reg_we && reg_addr == 12'h810 + 12'(4*k)) nxt[k] = nxt[k] & ~(reg_wdata & CMASK);
            nxt[k] = nxt[k] | ev[k];
        end
        @(posedge clk);
        for (int k = 0; k < 4; k++) m_pend[k] = nxt[k];
        if (reg_we && reg_addr == 12'h824) m_grp = reg_wdata;
        if (reg_we && reg_addr == 12'h828) m_arb = reg_wdata;
        @(negedge clk);
        reg_we = 1'b0;
        evt_done = '0; evt_src_err = '0; evt_dst_err = '0; evt_cfg_err = '0;
        check(tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
        check("R5", 32'(irq), 32'(exp_irq()));
        check("R7", grp_prio, m_grp);
        check("R7", arb_cfg, m_arb);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    initial begin
        #(CLK_PER * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] amap [12];
        amap = '{12'h800, 12'h804, 12'h808, 12'h80C, 12'h810, 12'h814,
                 12'h818, 12'h81C, 12'h820, 12'h824, 12'h828, 12'h830};
        void'($urandom(32'd2024));
        for (int k = 0; k < 4; k++) m_pend[k] = '0;
        m_grp = '0; m_arb = '0;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        evt_done = '0; evt_src_err = '0; evt_dst_err = '0; evt_cfg_err = '0;
        ch_irq_en = '1; ch_busy = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        for (int i = 0; i < 12; i++) begin
            reg_addr = amap[i]; #1;
            check("R9", reg_rdata, 32'h0);
        end
        check("R9", 32'(irq), 32'h0);

        // R2: initial clear-all write on every pending offset
        for (int k = 0; k < 4; k++) wr(12'h810 + 12'(4*k), 32'hFFFF_FFFF);

        // R8: all-ones events and writes stay inside N bits
        evt_done = '1; evt_src_err = '1; evt_dst_err = '1; evt_cfg_err = '1;
        reg_addr = 12'h810; tick();
        check("R8", reg_rdata, CMASK);
        reg_addr = 12'h80C; #1;
        check("R8", reg_rdata, CMASK);

        // R10: writes to a filtered view and busy change nothing
        wr(12'h800, 32'h0); wr(12'h820, 32'h0);
        reg_addr = 12'h810; #1;
        check("R10", reg_rdata, CMASK);

        // R2: a zero write leaves bits alone, a single one clears one bit
        wr(12'h814, 32'h0);
        check("R2", reg_rdata, CMASK);
        wr(12'h814, 32'h0000_0010);
        check("R2", reg_rdata, CMASK & ~32'h10);

        // R3: event and clear on the same bit, event wins
        evt_src_err = N'(32'h8);
        wr(12'h814, 32'h0000_0018);
        check("R3", reg_rdata, CMASK & ~32'h10);

        // R4/R5: no enables, no interrupt
        ch_irq_en = '0; reg_addr = 12'h808; tick();
        check("R5", 32'(irq), 32'h0);
        check("R4", reg_rdata, 32'h0);
        ch_irq_en = '1;

        // R7: equal-priority value and group word
        wr(12'h828, 32'h0); wr(12'h824, 32'hA5A5_0001);

        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            evt_done    = N'($urandom & $urandom & $urandom);
            evt_src_err = N'($urandom & $urandom & $urandom & $urandom);
            evt_dst_err = N'($urandom & $urandom & $urandom & $urandom);
            evt_cfg_err = N'($urandom & $urandom & $urandom & $urandom);
            if ($urandom_range(0, 7) == 0) ch_irq_en = N'($urandom);
            ch_busy   = N'($urandom);
            reg_addr  = amap[$urandom_range(0, 11)];
            reg_we    = ($urandom_range(0, 2) == 0);
            reg_wdata = $urandom;
            tick();
        end

        // R6: live busy read
        ch_busy = N'(32'h00F0_0F0F); reg_addr = 12'h820; #1;
        check("R6", reg_rdata, 32'h00F0_0F0F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule